// File: doc/BRIEF.md
# Fixed-point rounding right shifter

This block divides a fixed-point value by a power of two and rounds the quotient. It takes an unsigned word, a right-shift distance and a two-bit rounding selector. It returns the word shifted right, plus a rounding increment of 0 or 1. The increment is derived from three things: the bit just below the new least significant bit (the guard bit), the OR of every bit below the guard (the sticky bit), and the new least significant bit itself. Four rounding rules are supported. A scaling or averaging datapath would place this stage right after its wide arithmetic.

Operands arrive on a valid/ready input stream, and each result leaves on a valid/ready output stream after one register stage. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The mode selector and shift distance travel with the operand and are sampled on the same edge. Saturation and narrowing to a smaller width are not part of this block.

Top module: `rshift_round`

## Requirements
- R1: An operand accepted on one clock edge produces `out_valid` high after that edge. `out_data` then holds `(in_data >> in_shift) + inc`, truncated to DATA_W bits.
- R2: Mode 0 (nearest, ties up) sets `inc` to bit `in_shift-1` of the operand.
- R3: Mode 1 (nearest, ties to even) sets `inc = guard & (sticky | lsb)`. Here guard is bit `in_shift-1`, sticky is the OR of bits `in_shift-2` down to 0, and lsb is bit `in_shift`.
- R4: Mode 2 (toward zero) sets `inc` to 0, which is plain truncation.
- R5: Mode 3 (jam to odd) sets `inc` to 1 exactly when bit `in_shift` is 0 and at least one bit below position `in_shift` is 1.
- R6: With `in_shift` equal to 0, every mode returns the operand unchanged.
- R7: With `in_shift` equal to 1, the sticky term is 0. Mode 1 then rounds up only when both bit 0 and bit 1 of the operand are set.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` hold their values.
- R9: During and right after a synchronous active-high `rst`, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | DATA_W | Unsigned operand |
| in_shift | input | SHIFT_W | Right-shift distance, 0 to DATA_W-1 |
| in_mode | input | 2 | Rounding rule: 0 ties up, 1 ties even, 2 truncate, 3 jam odd |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W | Shifted and rounded result |

## Verification
The bench builds the block with DATA_W set to 8, so SHIFT_W is 3. With this width every shift distance, including the widest (7), can be tested with hand-checked operands. That covers shifts of 0 and 1, where the guard or sticky terms have no bits to draw on, and a shift of 7, where only the top bit survives. Exact ties, values above and below a tie, and results whose new least significant bit is odd or even are each driven through every mode. A stalled consumer shows whether the output register holds its result and the input stream holds off.

// File: rtl/rshift_round_pkg.sv
package rshift_round_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_TRUNC     = 2'd2,
    RND_JAM_ODD   = 2'd3
  } rnd_mode_e;

endpackage

// File: rtl/rshift_round_inc.sv
module rshift_round_inc
  import rshift_round_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHIFT_W-1:0] shift,
  input  rnd_mode_e          mode,
  output logic               inc
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] below_mask;   // bits shift-1 .. 0
  logic [DATA_W-1:0] sticky_mask;  // bits shift-2 .. 0
  logic [DATA_W-1:0] guard_sel;    // bit shift-1 only
  logic [DATA_W-1:0] lsb_sel;      // bit shift only
  logic guard_b, sticky_b, lsb_b, any_below;

  always_comb begin
    below_mask  = ~(ONES << shift);
    sticky_mask = below_mask >> 1;
    guard_sel   = below_mask ^ sticky_mask;
    lsb_sel     = ((below_mask << 1) | {{(DATA_W-1){1'b0}}, 1'b1}) ^ below_mask;
    guard_b     = |(value & guard_sel);
    sticky_b    = |(value & sticky_mask);
    lsb_b       = |(value & lsb_sel);
    any_below   = |(value & below_mask);
  end

  always_comb begin
    unique case (mode)
      RND_NEAR_UP:   inc = guard_b;
      RND_NEAR_EVEN: inc = guard_b & (sticky_b | lsb_b);
      RND_TRUNC:     inc = 1'b0;
      RND_JAM_ODD:   inc = ~lsb_b & any_below;
      default:       inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/rshift_round_reg.sv
module rshift_round_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);

  assign up_ready = ~dn_valid | dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |-> !up_ready);

endmodule

// File: rtl/rshift_round.sv
module rshift_round
  import rshift_round_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [1:0]         in_mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic              inc;
  logic [DATA_W-1:0] rounded;
  logic              accept;

  rshift_round_inc #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_inc (
    .value (in_data),
    .shift (in_shift),
    .mode  (rnd_mode_e'(in_mode)),
    .inc   (inc)
  );

  assign rounded = (in_data >> in_shift) + {{(DATA_W-1){1'b0}}, inc};
  assign accept  = in_valid & in_ready;

  rshift_round_reg #(.DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (rounded),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R4
  trunc_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'd2) |=> (out_data == ($past(in_data) >> $past(in_shift))));

  // R5
  jam_odd_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == 2'd3 && ((in_data & ~(ONES << in_shift)) != '0)) |=> out_data[0]);

  // R6
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_shift == '0) |=> (out_data == $past(in_data)));

endmodule

// File: tb/tb_rshift_round.sv
module tb_rshift_round;

  localparam int DW = 8;
  localparam int SW = 3;
  localparam int NV = 26;

  // {mode[2], shift[3], value[8], expected[8]}
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd3, 8'h6D, 8'd14}, {2'd1, 3'd3, 8'h6D, 8'd14},
    {2'd2, 3'd3, 8'h6D, 8'd13}, {2'd3, 3'd3, 8'h6D, 8'd13},
    {2'd3, 3'd2, 8'h68, 8'd26}, {2'd3, 3'd2, 8'h69, 8'd27},
    {2'd0, 3'd2, 8'h69, 8'd26}, {2'd1, 3'd2, 8'h69, 8'd26},
    {2'd0, 3'd2, 8'h0A, 8'd3},  {2'd1, 3'd2, 8'h0A, 8'd2},
    {2'd2, 3'd2, 8'h0A, 8'd2},  {2'd3, 3'd2, 8'h0A, 8'd3},
    {2'd1, 3'd2, 8'h0E, 8'd4},  {2'd3, 3'd2, 8'h0E, 8'd3},
    {2'd1, 3'd3, 8'h16, 8'd3},  {2'd3, 3'd3, 8'h11, 8'd3},
    {2'd1, 3'd1, 8'h03, 8'd2},  {2'd1, 3'd1, 8'h01, 8'd0},
    {2'd0, 3'd1, 8'h01, 8'd1},  {2'd3, 3'd1, 8'h03, 8'd1},
    {2'd0, 3'd0, 8'hFF, 8'hFF}, {2'd1, 3'd0, 8'hA5, 8'hA5},
    {2'd3, 3'd0, 8'hA4, 8'hA4}, {2'd1, 3'd7, 8'hC0, 8'd2},
    {2'd1, 3'd7, 8'h40, 8'd0},  {2'd0, 3'd7, 8'h40, 8'd1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_shift = '0;
  logic [1:0]    in_mode = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rshift_round #(.DATA_W(DW), .SHIFT_W(SW)) dut (
    .clk, .rst, .in_valid, .in_ready, .in_data, .in_shift, .in_mode,
    .out_valid, .out_ready, .out_data
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic [2:0] s);
    if (s == 3'd0) return "R6";
    if (s == 3'd1) return "R7";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic push(input logic [1:0] m, input logic [2:0] s, input logic [7:0] v);
    in_valid = 1'b1; in_mode = m; in_shift = s; in_data = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: no result while in reset
    chk("R9", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", out_valid, 0);
    chk("R8", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      push(VEC[i][20:19], VEC[i][18:16], VEC[i][15:8]);
      // R1: result registered one edge after acceptance
      chk("R1", out_valid, 1);
      chk(tag_of(VEC[i][20:19], VEC[i][18:16]), out_data, VEC[i][7:0]);
    end

    @(negedge clk);
    chk("R1", out_valid, 0);

    // R8: stalled consumer
    out_ready = 1'b0;
    in_valid = 1'b1; in_mode = 2'd2; in_shift = 3'd4; in_data = 8'hF0;
    @(posedge clk);
    @(negedge clk);
    in_data = 8'h80; in_shift = 3'd0;
    chk("R8", out_valid, 1);
    chk("R8", out_data, 15);
    chk("R8", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R8", out_valid, 1);
    chk("R8", out_data, 15);
    chk("R8", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", out_data, 8'h80);
    chk("R8", out_valid, 1);
    @(negedge clk);
    chk("R8", out_valid, 0);

    // R9: reset clears a pending result
    push(2'd0, 3'd1, 8'h05);
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9", out_valid, 0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", out_valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule